// File: doc/BRIEF.md
# Chained Serializer Readout Controller

This block is an SPI master that reads a daisy chain of 8-input industrial serializers in one transfer. A one-cycle start request opens a transfer of 8 bits per chip in narrow mode or 16 bits per chip in wide mode. The mode is latched at start and applies to every chip in the chain. In wide mode, each chip sends its input byte and then a status byte. The block checks a 5-bit CRC in that status byte, decodes the alarm bits, and combines the result with a fault pin sampled at the end of the transfer.

When the transfer completes, the block registers all per-chip results on the same edge and raises a one-cycle done pulse. The results are the input bits, a valid flag, the CRC, overtemperature, undervoltage and warning flags, and the mapped fault pin. A chip judged faulting reads back as zero with its valid flag low, while healthy chips in the same chain still deliver their data. The block also holds two debounce-select outputs, one pair per chip or one shared pair, loaded from a configuration input.

Top module: `serchain_reader`

## Requirements
- R1: While idle, `cs_n` is high and `sclk` is low. A `start` pulse drives `cs_n` low on the next cycle and clocks exactly 16×N_CHIPS (wide) or 8×N_CHIPS (narrow) rising `sclk` edges. Each `sclk` high or low phase lasts HALF_DIV clock cycles, with MSB-first sampling on the rising edge. `done` is a one-cycle pulse raised together with `cs_n` returning high.
- R2: Receive byte k counts from the first byte on the wire. In wide mode, chip i's input byte is byte 2i and its status byte is byte 2i+1. In narrow mode, chip i's input byte is byte i. Host bit n is bit n mod 8 of chip n/8.
- R3: In wide mode, `crc_err[i]` is set when status bits 7:3 differ from the remainder of (input byte × x^5) modulo x^5+x^4+x^2+1, with zero initial value.
- R4: In wide mode, `over_temp[i]` is status bit 1 high. `under_volt[i]` is status bit 2 low unless `ignore_uv` is set. `volt_warn[i]` is status bit 0 low and never makes a chip faulting.
- R5: In narrow mode, all status-derived flags read zero, and only the fault pin can make a chip faulting.
- R6: With FLT_SHARED=1, `fault_in[0]` applies to every chip; otherwise chip i uses `fault_in[i]`. `pin_fault[i]` reports the pin mapped to chip i.
- R7: With `ignore_uv` set, neither undervoltage nor the fault pin makes a chip faulting.
- R8: A chip is faulting on an unignored fault pin or, in wide mode, on a CRC error, overtemperature or unignored undervoltage. A faulting chip has `chip_ok` low and its 8 bits of `in_bits` read zero; other chips deliver their input byte.
- R9: All result outputs reset to zero and change only on the edge that raises `done`, even if inputs change while idle.
- R10: Debounce output j takes `db0_out[j]=db_cfg[2j]` and `db1_out[j]=db_cfg[2j+1]` only on a cycle with `db_load` high. With DB_SHARED=1 there is a single pair.
- R11: A `start` pulse during a transfer is ignored, and the running transfer keeps its mode and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read the chain |
| wide_mode | input | 1 | 1 = input and status byte per chip, 0 = input byte only |
| ignore_uv | input | 1 | Exclude undervoltage and fault pin from the faulting decision |
| fault_in | input | NF | Fault pins (1 if shared, else N_CHIPS) |
| db_load | input | 1 | Load debounce configuration |
| db_cfg | input | 2*ND | Debounce codes, two bits per pair |
| miso | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chain select, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| in_bits | output | 8*N_CHIPS | Input bits, zero for faulting chips |
| chip_ok | output | N_CHIPS | Per-chip valid flag |
| crc_err | output | N_CHIPS | Per-chip CRC mismatch |
| over_temp | output | N_CHIPS | Per-chip overtemperature |
| under_volt | output | N_CHIPS | Per-chip undervoltage alarm |
| volt_warn | output | N_CHIPS | Per-chip voltage warning |
| pin_fault | output | N_CHIPS | Fault pin mapped to each chip |
| db0_out | output | ND | Debounce select bit 0 |
| db1_out | output | ND | Debounce select bit 1 |

## Verification
A start request and a debounce load can both land while a transfer is running, and the shift engine must not be disturbed by either. The bench provokes this by pulsing `start` with the opposite mode in the middle of a wide transfer and loading new debounce codes in the same window. It then judges the result by the count of rising `sclk` edges, the decoded chip data and the debounce outputs. It also sweeps all 256 input byte values in wide mode, with the status bits, fault pins and ignore option varied together, on a per-chip-pin instance and a shared-pin instance fed by the same serial stream.

// File: rtl/serchain_pkg.sv
`timescale 1ns/1ps
package serchain_pkg;

  typedef enum logic {ST_IDLE, ST_XFER} xfer_st_e;

  // Status check value: the top-aligned 8-bit register form of the
  // 5-bit generator, stepped once per data bit.
  function automatic logic [4:0] crc5_of(input logic [7:0] d);
    logic [7:0] t;
    t = d;
    for (int k = 0; k < 8; k++) begin
      t = t[7] ? ((t << 1) ^ 8'hA8) : (t << 1);
    end
    return t[7:3];
  endfunction

endpackage

// File: rtl/serchain_shift.sv
`timescale 1ns/1ps
module serchain_shift
  import serchain_pkg::*;
#(
  parameter int N_CHIPS  = 2,
  parameter int HALF_DIV = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   wide_mode,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   cs_n,
  output logic                   busy,
  output logic                   done,
  output logic                   fin,
  output logic                   xfer_wide,
  output logic [16*N_CHIPS-1:0]  rx
);
  localparam int MAXB = 16 * N_CHIPS;
  localparam int CW   = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam int BW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] RISE_AT = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(2 * HALF_DIV - 1);
  localparam logic [BW-1:0] LAST_W  = BW'(MAXB - 1);
  localparam logic [BW-1:0] LAST_N  = BW'(8 * N_CHIPS - 1);

  xfer_st_e          st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              wide_q, wide_d;
  logic              sclk_q, sclk_d;
  logic              cs_q, cs_d;
  logic              done_q;
  logic              fin_c;
  logic [MAXB-1:0]   rx_q, rx_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    wide_d = wide_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    rx_d   = rx_q;
    fin_c  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_XFER;
          cs_d   = 1'b0;
          cnt_d  = '0;
          bit_d  = '0;
          wide_d = wide_mode;
        end
      end
      ST_XFER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == RISE_AT) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[MAXB-2:0], miso};
        end
        if (cnt_q == FALL_AT) begin
          cnt_d  = '0;
          sclk_d = 1'b0;
          bit_d  = bit_q + 1'b1;
          if (bit_q == (wide_q ? LAST_W : LAST_N)) begin
            st_d  = ST_IDLE;
            cs_d  = 1'b1;
            fin_c = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      wide_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      wide_q <= wide_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= fin_c;
      rx_q   <= rx_d;
    end
  end

  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign busy      = (st_q == ST_XFER);
  assign done      = done_q;
  assign fin       = fin_c;
  assign xfer_wide = wide_q;
  assign rx        = rx_q;

  // R1: chain deselected and clock parked whenever no transfer runs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (cs_q && !sclk_q));
  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11: mode of a running transfer never changes
  p_mode_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER) |=> $stable(wide_q));

endmodule

// File: rtl/serchain_chip.sv
`timescale 1ns/1ps
module serchain_chip
  import serchain_pkg::*;
(
  input  logic       wide,
  input  logic       ign_uv,
  input  logic       pin,
  input  logic [7:0] in_byte,
  input  logic [7:0] st_byte,
  output logic       crc_bad,
  output logic       hot,
  output logic       low_v,
  output logic       warn_v,
  output logic       bad
);
  always_comb begin
    crc_bad = wide && (st_byte[7:3] != crc5_of(in_byte));
    hot     = wide && st_byte[1];
    low_v   = wide && !st_byte[2] && !ign_uv;
    warn_v  = wide && !st_byte[0];
    bad     = (pin && !ign_uv) || crc_bad || hot || low_v;
  end
endmodule

// File: rtl/serchain_dbsel.sv
`timescale 1ns/1ps
module serchain_dbsel #(
  parameter int ND = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2*ND-1:0] cfg,
  output logic [ND-1:0] db0,
  output logic [ND-1:0] db1
);
  for (genvar j = 0; j < ND; j++) begin : g_pair
    logic [1:0] sel_q, sel_d;

    always_comb begin
      sel_d = sel_q;
      if (load) sel_d = cfg[2*j +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 2'b00;
      else        sel_q <= sel_d;
    end

    assign db0[j] = sel_q[0];
    assign db1[j] = sel_q[1];

    // R10: pair holds unless a load was requested
    p_db_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> ($stable(db0[j]) && $stable(db1[j])));
  end
endmodule

// File: rtl/serchain_reader.sv
`timescale 1ns/1ps
module serchain_reader #(
  parameter int N_CHIPS    = 2,
  parameter int HALF_DIV   = 2,
  parameter int FLT_SHARED = 0,
  parameter int DB_SHARED  = 0,
  localparam int NF = (FLT_SHARED != 0) ? 1 : N_CHIPS,
  localparam int ND = (DB_SHARED != 0) ? 1 : N_CHIPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wide_mode,
  input  logic                 ignore_uv,
  input  logic [NF-1:0]        fault_in,
  input  logic                 db_load,
  input  logic [2*ND-1:0]      db_cfg,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 busy,
  output logic                 done,
  output logic [8*N_CHIPS-1:0] in_bits,
  output logic [N_CHIPS-1:0]   chip_ok,
  output logic [N_CHIPS-1:0]   crc_err,
  output logic [N_CHIPS-1:0]   over_temp,
  output logic [N_CHIPS-1:0]   under_volt,
  output logic [N_CHIPS-1:0]   volt_warn,
  output logic [N_CHIPS-1:0]   pin_fault,
  output logic [ND-1:0]        db0_out,
  output logic [ND-1:0]        db1_out
);
  localparam int MAXB = 16 * N_CHIPS;
  localparam int NB   = 8 * N_CHIPS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic            fin, xwide;
  logic [MAXB-1:0] rx;

  serchain_shift #(.N_CHIPS(N_CHIPS), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_i), .start(start), .wide_mode(wide_mode),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
    .fin(fin), .xfer_wide(xwide), .rx(rx)
  );

  logic [NB-1:0]      data_c;
  logic [N_CHIPS-1:0] ok_c, crc_c, ot_c, uv_c, uw_c, pin_c;

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
    logic [7:0] in_sel, st_sel;
    logic       bad;

    assign in_sel = xwide ? rx[MAXB-1-16*g -: 8] : rx[NB-1-8*g -: 8];
    assign st_sel = xwide ? rx[MAXB-9-16*g -: 8] : 8'h00;

    if (FLT_SHARED != 0) begin : g_fsh
      assign pin_c[g] = fault_in[0];
    end else begin : g_fpc
      assign pin_c[g] = fault_in[g];
    end

    serchain_chip u_chk (
      .wide(xwide), .ign_uv(ignore_uv), .pin(pin_c[g]),
      .in_byte(in_sel), .st_byte(st_sel),
      .crc_bad(crc_c[g]), .hot(ot_c[g]), .low_v(uv_c[g]),
      .warn_v(uw_c[g]), .bad(bad)
    );

    assign ok_c[g]          = !bad;
    assign data_c[8*g +: 8] = bad ? 8'h00 : in_sel;

    // R8: a chip flagged invalid never exposes data
    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_i)
      !chip_ok[g] |-> (in_bits[8*g +: 8] == 8'h00));
  end

  logic [NB-1:0]      data_q, data_d;
  logic [N_CHIPS-1:0] ok_q, ok_d, crc_q, crc_d, ot_q, ot_d;
  logic [N_CHIPS-1:0] uv_q, uv_d, uw_q, uw_d, pf_q, pf_d;

  always_comb begin
    data_d = data_q;
    ok_d   = ok_q;
    crc_d  = crc_q;
    ot_d   = ot_q;
    uv_d   = uv_q;
    uw_d   = uw_q;
    pf_d   = pf_q;
    if (fin) begin
      data_d = data_c;
      ok_d   = ok_c;
      crc_d  = crc_c;
      ot_d   = ot_c;
      uv_d   = uv_c;
      uw_d   = uw_c;
      pf_d   = pin_c;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      data_q <= '0;
      ok_q   <= '0;
      crc_q  <= '0;
      ot_q   <= '0;
      uv_q   <= '0;
      uw_q   <= '0;
      pf_q   <= '0;
    end else begin
      data_q <= data_d;
      ok_q   <= ok_d;
      crc_q  <= crc_d;
      ot_q   <= ot_d;
      uv_q   <= uv_d;
      uw_q   <= uw_d;
      pf_q   <= pf_d;
    end
  end

  assign in_bits    = data_q;
  assign chip_ok    = ok_q;
  assign crc_err    = crc_q;
  assign over_temp  = ot_q;
  assign under_volt = uv_q;
  assign volt_warn  = uw_q;
  assign pin_fault  = pf_q;

  serchain_dbsel #(.ND(ND)) u_db (
    .clk(clk), .rst_n(rst_i), .load(db_load), .cfg(db_cfg),
    .db0(db0_out), .db1(db1_out)
  );

  // R5: a narrow read leaves every status-derived flag clear
  p_narrow_flags_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (done && !xwide) |-> ((crc_err == '0) && (over_temp == '0) &&
                          (under_volt == '0) && (volt_warn == '0)));
  // R9: results move only together with the completion pulse
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_i)
    !done |-> ($stable(in_bits) && $stable(chip_ok) && $stable(crc_err) &&
               $stable(pin_fault)));

endmodule

// File: tb/sim_serchain_reader.sv
`timescale 1ns/1ps
module sim_serchain_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wide = 1'b0, ign = 1'b0, db_load = 1'b0;
  logic [1:0] fp = 2'b00;
  logic       fs = 1'b0;
  logic [3:0] dcfg0 = 4'h0;
  logic [1:0] dcfg1 = 2'h0;
  logic [31:0] frame = 32'h0;
  logic miso;

  logic sclk0, cs0, busy0, done0, sclk1, cs1, busy1, done1;
  logic [15:0] bits0, bits1;
  logic [1:0] ok0, crc0, ot0, uv0, uw0, pf0, d00, d10;
  logic [1:0] ok1, crc1, ot1, uv1, uw1, pf1;
  logic [0:0] d01, d11;

  int n_chk = 0, n_fail = 0;
  int fall_cnt = 0, rise_cnt = 0;

  always #2.5 clk = ~clk;

  serchain_reader #(.N_CHIPS(2), .HALF_DIV(2), .FLT_SHARED(0), .DB_SHARED(0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide), .ignore_uv(ign),
    .fault_in(fp), .db_load(db_load), .db_cfg(dcfg0), .miso(miso),
    .sclk(sclk0), .cs_n(cs0), .busy(busy0), .done(done0), .in_bits(bits0),
    .chip_ok(ok0), .crc_err(crc0), .over_temp(ot0), .under_volt(uv0),
    .volt_warn(uw0), .pin_fault(pf0), .db0_out(d00), .db1_out(d10)
  );

  serchain_reader #(.N_CHIPS(2), .HALF_DIV(2), .FLT_SHARED(1), .DB_SHARED(1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide), .ignore_uv(ign),
    .fault_in(fs), .db_load(db_load), .db_cfg(dcfg1), .miso(miso),
    .sclk(sclk1), .cs_n(cs1), .busy(busy1), .done(done1), .in_bits(bits1),
    .chip_ok(ok1), .crc_err(crc1), .over_temp(ot1), .under_volt(uv1),
    .volt_warn(uw1), .pin_fault(pf1), .db0_out(d01), .db1_out(d11)
  );

  // chain model: shifts the next bit out on each falling clock edge
  always @(negedge sclk0 or posedge cs0) begin
    if (cs0) fall_cnt <= 0;
    else     fall_cnt <= fall_cnt + 1;
  end
  assign miso = (fall_cnt < 32) ? frame[31 - fall_cnt] : 1'b0;

  always @(posedge sclk0) rise_cnt <= rise_cnt + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] crc_ref(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b00000};
    for (int b = 12; b >= 5; b--)
      if (r[b]) r = r ^ (13'b0000000110101 << (b - 5));
    return r[4:0];
  endfunction

  task automatic wait_done();
    int n;
    n = 0;
    while (!done0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input bit w, input bit ig, input logic [1:0] pins, input logic spin,
                     input logic [7:0] a0, input logic [7:0] s0,
                     input logic [7:0] a1, input logic [7:0] s1);
    logic [15:0] eb, eb1;
    logic [1:0]  eok, eok1, ecrc, eot, euv, euw;
    logic [7:0]  din, dst;
    logic        ce, oe, ue, bad, bad1;
    int          r0;
    @(negedge clk);
    wide = w; ign = ig; fp = pins; fs = spin;
    frame = w ? {a0, s0, a1, s1} : {a0, a1, 16'h0000};
    r0 = rise_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 select low after start", cs0, 1'b0);
    wait_done();
    for (int i = 0; i < 2; i++) begin
      din = (i == 0) ? a0 : a1;
      dst = (i == 0) ? s0 : s1;
      ce = w && (dst[7:3] != crc_ref(din));
      oe = w && dst[1];
      ue = w && !dst[2] && !ig;
      ecrc[i] = ce; eot[i] = oe; euv[i] = ue; euw[i] = w && !dst[0];
      bad  = (pins[i] && !ig) || ce || oe || ue;
      bad1 = (spin && !ig) || ce || oe || ue;
      eok[i] = !bad;  eb[8*i +: 8]  = bad  ? 8'h00 : din;
      eok1[i] = !bad1; eb1[8*i +: 8] = bad1 ? 8'h00 : din;
    end
    chk("R1 done seen", done0, 1'b1);
    chk("R1 select high at done", cs0, 1'b1);
    chk("R1 clock edge count", rise_cnt - r0, w ? 32 : 16);
    chk("R2 R8 input bits", bits0, eb);
    chk("R8 R7 valid flags", ok0, eok);
    chk("R3 crc flags", crc0, ecrc);
    chk("R4 overtemp", ot0, eot);
    chk("R4 R7 undervolt", uv0, euv);
    chk("R4 R5 warning", uw0, euw);
    chk("R6 per-chip pins", pf0, pins);
    chk("R6 shared pin flags", pf1, {spin, spin});
    chk("R6 shared pin valid", ok1, eok1);
    chk("R6 shared pin bits", bits1, eb1);
    @(negedge clk);
    chk("R1 done single cycle", done0, 1'b0);
  endtask

  initial begin
    logic [15:0] snap_b;
    logic [1:0]  snap_ok;
    logic [7:0]  k8, nk;
    int          r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset select", cs0, 1'b1);
    chk("R1 reset clock", sclk0, 1'b0);
    chk("R9 reset bits", bits0, 16'h0);
    chk("R9 reset valid", ok0, 2'b00);
    chk("R10 reset debounce", {d10, d00}, 4'h0);

    // wide-mode sweep over every input byte value
    for (int k = 0; k < 256; k++) begin
      k8 = 8'(k);
      nk = ~k8;
      run(1'b1, k8[7], k8[1:0] & {k8[4], k8[6]}, k8[5],
          k8, {crc_ref(k8), k8[2:0]},
          nk, {crc_ref(nk) ^ {4'b0000, k8[3]}, k8[6:4]});
    end

    // narrow-mode sweep
    for (int k = 0; k < 64; k++) begin
      k8 = 8'(k);
      run(1'b0, k8[0], k8[2:1], k8[3], 8'(k * 37), 8'hFF, 8'(k * 11 + 3), 8'h00);
    end

    // R9: inputs change while idle, results must stay put
    run(1'b1, 1'b0, 2'b00, 1'b0, 8'hC3, {crc_ref(8'hC3), 3'b101},
        8'h3C, {crc_ref(8'h3C), 3'b101});
    snap_b = bits0; snap_ok = ok0;
    @(negedge clk);
    fp = 2'b11; fs = 1'b1; ign = 1'b1; frame = 32'hFFFF_0000;
    repeat (20) @(negedge clk);
    chk("R9 bits held while idle", bits0, snap_b);
    chk("R9 valid held while idle", ok0, snap_ok);

    // R11: start in mid-transfer with the other mode; R10 load in same window
    @(negedge clk);
    wide = 1'b1; ign = 1'b0; fp = 2'b00; fs = 1'b0;
    frame = {8'h5A, crc_ref(8'h5A), 3'b101, 8'hA5, crc_ref(8'hA5), 3'b101};
    r0 = rise_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    wide = 1'b0; start = 1'b1; dcfg0 = 4'b1001; dcfg1 = 2'b10; db_load = 1'b1;
    @(negedge clk);
    start = 1'b0; db_load = 1'b0;
    chk("R10 pair0 bit0 loaded", d00[0], 1'b1);
    chk("R10 pair0 bit1 loaded", d10[0], 1'b0);
    chk("R10 pair1 bit0 loaded", d00[1], 1'b0);
    chk("R10 pair1 bit1 loaded", d10[1], 1'b1);
    chk("R10 shared pair loaded", {d11, d01}, 2'b10);
    wait_done();
    chk("R11 length kept", rise_cnt - r0, 32);
    chk("R11 data kept", bits0, 16'hA55A);
    chk("R11 valid kept", ok0, 2'b11);
    @(negedge clk);
    chk("R11 no second transfer", cs0, 1'b1);

    // R10: configuration without load has no effect
    dcfg0 = 4'b0110; dcfg1 = 2'b01;
    repeat (5) @(negedge clk);
    chk("R10 held without load", {d10, d00}, 4'b1001);
    chk("R10 shared held without load", {d11, d01}, 2'b10);
    db_load = 1'b1;
    @(negedge clk);
    db_load = 1'b0;
    chk("R10 reload", {d10, d00}, 4'b0110);
    chk("R10 shared reload", {d11, d01}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule